// File: doc/BRIEF.md
# System control register page with interrupt combiner

This block is the system-control page of an I/O companion chip. It is a byte-addressed register file behind an 8-bit offset bus. One byte is read or written per access, so registers wider than a byte are reached one lane at a time. The page holds a fixed revision code and three interrupt registers: pending, enable and routing. It also holds a set of configuration registers that are one, two, three or four bytes wide and are stored without any side effect.

Eight level-sensitive interrupt lines from sub-devices feed the pending register. A pending bit copies its line whenever that line changes level, and software can overwrite the register at any time. The host interrupt is the OR of pending bits that are enabled. A host reads the pending register to find the source and writes the enable register to select sources.

Top module: `sysctl_regs`

## Requirements
- R1: Offset 0x08 reads the revision code REV_ID (default 3) and offset 0x09 reads 0x00. Writes to either offset leave those values unchanged.
- R2: Pending is at 0x50, enable at 0x52 and routing at 0x54. Each is one byte, and each reads back the last value written to it while no sub-line changes. Routing is storage only.
- R3: When sub-line n differs from its value at the previous active clock edge, pending bit n takes the new line level at that edge. A line that is held steady leaves the bit to software, so writing 0 clears the bit while the line stays high.
- R4: A pending write and a line change can occur in the same cycle. The changed bits then take the line level and all other bits take the written data.
- R5: host_irq is high exactly while (pending AND enable) is nonzero. It follows the registers with no extra cycle.
- R6: The two-byte registers at 0x60, 0x98, 0x9A and 0xE4 have the low byte at the base offset and the high byte at base+1. A byte write changes only its own byte.
- R7: The four-byte register at 0x9C occupies 0x9C to 0x9F in little-endian order. Each byte is written independently.
- R8: Three-byte arrays start at 0x64, 0x68, 0x6C, 0x70, 0x80, 0x84 and 0x88, at base+0 to base+2. base+3 is not mapped.
- R9: Single-byte registers sit at 0xA0, 0xA1, 0xE0, 0xFC and 0xFF.
- R10: A read of an unmapped offset returns 0x00. A write to an unmapped offset changes no readable byte.
- R11: While rst_n is low, every register reads zero and host_irq is low. After rst_n rises, writes and line sampling take effect from the third rising clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the byte at addr |
| addr | input | 8 | Byte offset within the page |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| sub_irq | input | 8 | Level interrupt lines from sub-devices |
| host_irq | output | 1 | Combined host interrupt |

## Verification
A software write to the pending register and a level change on a sub-line can land on the same clock edge, and the two compete for the same bits. The bench forces this collision directly in both directions: a rising line with a zero write, and a falling line with an all-ones write. A long pseudo-random run then mixes writes and line toggles. The behavioural model decides every such edge bit by bit, and the bench compares read data and host_irq against it after every clock.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef logic [7:0] byte_t;

  localparam byte_t OFS_REV_LO = 8'h08;
  localparam byte_t OFS_REV_HI = 8'h09;
  localparam byte_t OFS_PEND   = 8'h50;
  localparam byte_t OFS_ENA    = 8'h52;
  localparam byte_t OFS_ROUTE  = 8'h54;

  // configuration register groups: base offset and width in bytes
  localparam int NUM_GRP = 17;
  localparam byte_t GRP_BASE [NUM_GRP] = '{
    8'h60, 8'h64, 8'h68, 8'h6C, 8'h70, 8'h80, 8'h84, 8'h88,
    8'h98, 8'h9A, 8'h9C, 8'hA0, 8'hA1, 8'hE0, 8'hE4, 8'hFC, 8'hFF
  };
  localparam int GRP_LEN [NUM_GRP] = '{
    2, 3, 3, 3, 3, 3, 3, 3, 2, 2, 4, 1, 1, 1, 2, 1, 1
  };

  function automatic int cfg_count();
    int n;
    n = 0;
    for (int g = 0; g < NUM_GRP; g++) n += GRP_LEN[g];
    return n;
  endfunction

  localparam int NUM_CFG = cfg_count();

  function automatic byte_t cfg_offset(int idx);
    int n;
    byte_t r;
    n = 0;
    r = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int k = 0; k < GRP_LEN[g]; k++) begin
        if (n == idx) r = GRP_BASE[g] + byte_t'(k);
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic is_cfg(byte_t a);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_CFG; i++) if (cfg_offset(i) == a) hit = 1'b1;
    return hit;
  endfunction

  typedef struct packed {
    logic rev_lo;
    logic rev_hi;
    logic pend;
    logic ena;
    logic route;
  } fixed_sel_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int N_CFG = NUM_CFG
) (
  input  logic [7:0]       addr,
  output logic [N_CFG-1:0] cfg_hit,
  output fixed_sel_t       fsel
);

  for (genvar i = 0; i < N_CFG; i++) begin : g_hit
    localparam byte_t OFS = cfg_offset(i);
    assign cfg_hit[i] = (addr == OFS);
  end

  always_comb begin
    fsel.rev_lo = (addr == OFS_REV_LO);
    fsel.rev_hi = (addr == OFS_REV_HI);
    fsel.pend   = (addr == OFS_PEND);
    fsel.ena    = (addr == OFS_ENA);
    fsel.route  = (addr == OFS_ROUTE);
  end

endmodule

// File: rtl/sysctl_cfg_bank.sv
module sysctl_cfg_bank #(
  parameter int N_CFG = 38,
  localparam int QW = N_CFG * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [N_CFG-1:0] cfg_hit,
  input  logic [7:0]       wdata,
  output logic [QW-1:0]    cfg_q,
  output logic [7:0]       rd_cfg
);

  for (genvar i = 0; i < N_CFG; i++) begin : g_byte
    logic       ce;
    logic [7:0] d;

    always_comb begin
      ce = wr_en & cfg_hit[i];
      d  = ce ? wdata : cfg_q[i*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q[i*8 +: 8] <= '0;
      else if (ce) cfg_q[i*8 +: 8] <= d;
    end
  end

  always_comb begin
    rd_cfg = '0;
    for (int i = 0; i < N_CFG; i++)
      rd_cfg = rd_cfg | ({8{cfg_hit[i]}} & cfg_q[i*8 +: 8]);
  end

endmodule

// File: rtl/sysctl_irq.sv
module sysctl_irq #(
  parameter int NSUB = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSUB-1:0] sub_irq,
  input  logic            wr_pend,
  input  logic            wr_ena,
  input  logic            wr_route,
  input  logic [7:0]      wdata,
  output logic [NSUB-1:0] pend_q,
  output logic [NSUB-1:0] ena_q,
  output logic [7:0]      route_q,
  output logic            host_irq
);

  logic [NSUB-1:0] line_q;
  logic [NSUB-1:0] pend_d;
  logic [NSUB-1:0] ena_d;
  logic [7:0]      route_d;

  always_comb begin
    for (int n = 0; n < NSUB; n++) begin
      if (sub_irq[n] != line_q[n]) pend_d[n] = sub_irq[n];
      else if (wr_pend)            pend_d[n] = wdata[n];
      else                         pend_d[n] = pend_q[n];
    end
    ena_d   = wr_ena   ? wdata[NSUB-1:0] : ena_q;
    route_d = wr_route ? wdata           : route_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      pend_q  <= '0;
      ena_q   <= '0;
      route_q <= '0;
    end else begin
      line_q  <= sub_irq;
      pend_q  <= pend_d;
      ena_q   <= ena_d;
      route_q <= route_d;
    end
  end

  assign host_irq = |(pend_q & ena_q);

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter byte_t REV_ID  = 8'h03,
  parameter int    NUM_SUB = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic [NUM_SUB-1:0] sub_irq,
  output logic               host_irq
);

  localparam int QW = NUM_CFG * 8;

  logic [1:0]         rst_sync;
  logic               rst_sync_n;
  logic [NUM_CFG-1:0] cfg_hit;
  fixed_sel_t         fsel;
  logic [QW-1:0]      cfg_q;
  logic [7:0]         rd_cfg;
  logic [NUM_SUB-1:0] pend_q;
  logic [NUM_SUB-1:0] ena_q;
  logic [7:0]         route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  sysctl_decode #(.N_CFG(NUM_CFG)) u_dec (
    .addr    (addr),
    .cfg_hit (cfg_hit),
    .fsel    (fsel)
  );

  sysctl_cfg_bank #(.N_CFG(NUM_CFG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .cfg_hit (cfg_hit),
    .wdata   (wdata),
    .cfg_q   (cfg_q),
    .rd_cfg  (rd_cfg)
  );

  sysctl_irq #(.NSUB(NUM_SUB)) u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sub_irq  (sub_irq),
    .wr_pend  (wr_en & fsel.pend),
    .wr_ena   (wr_en & fsel.ena),
    .wr_route (wr_en & fsel.route),
    .wdata    (wdata),
    .pend_q   (pend_q),
    .ena_q    (ena_q),
    .route_q  (route_q),
    .host_irq (host_irq)
  );

  always_comb begin
    rdata = rd_cfg;
    if (fsel.rev_lo) rdata = REV_ID;
    if (fsel.rev_hi) rdata = 8'h00;
    if (fsel.pend)   rdata = 8'(pend_q);
    if (fsel.ena)    rdata = 8'(ena_q);
    if (fsel.route)  rdata = route_q;
  end

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
  import sysctl_pkg::*;
#(
  parameter byte_t REV_ID  = 8'h03,
  parameter int    NUM_SUB = 8,
  parameter int    N_CFG   = NUM_CFG
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [7:0]         addr,
  input logic [7:0]         rdata,
  input logic [NUM_SUB-1:0] sub_irq,
  input logic               host_irq,
  input logic [NUM_SUB-1:0] pend_q,
  input logic [N_CFG*8-1:0] cfg_q,
  input logic [N_CFG-1:0]   cfg_hit
);

  logic [1:0]         cyc;
  logic [N_CFG*8-1:0] hit_bytes;
  logic               mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  always_comb begin
    for (int i = 0; i < N_CFG; i++) hit_bytes[i*8 +: 8] = {8{cfg_hit[i]}};
    mapped = is_cfg(addr) || addr == OFS_REV_LO || addr == OFS_REV_HI ||
             addr == OFS_PEND || addr == OFS_ENA || addr == OFS_ROUTE;
  end

  a_r1_revision: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_REV_LO) |-> (rdata == REV_ID));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!mapped) |-> (rdata == 8'h00));

  a_r6_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((cfg_q ^ $past(cfg_q)) & ~$past(hit_bytes)) == '0));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(cfg_q));

  a_r3_follow_line: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $past(sub_irq) != $past(sub_irq, 2)) |->
    (((pend_q ^ $past(sub_irq)) & ($past(sub_irq) ^ $past(sub_irq, 2))) == '0));

  a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $rose(host_irq)) |->
    (($past(wr_en) && ($past(addr) == OFS_PEND || $past(addr) == OFS_ENA)) ||
     ($past(sub_irq) != $past(sub_irq, 2))));

  a_r5_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $fell(host_irq)) |->
    (($past(wr_en) && ($past(addr) == OFS_PEND || $past(addr) == OFS_ENA)) ||
     ($past(sub_irq) != $past(sub_irq, 2))));

  always @(negedge clk) begin
    if (!rst_n) a_r11_reset_quiet: assert (!host_irq && pend_q == '0);
  end

endmodule

bind sysctl_regs sysctl_regs_chk #(
  .REV_ID  (REV_ID),
  .NUM_SUB (NUM_SUB),
  .N_CFG   (sysctl_pkg::NUM_CFG)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .rdata    (rdata),
  .sub_irq  (sub_irq),
  .host_irq (host_irq),
  .pend_q   (pend_q),
  .cfg_q    (cfg_q),
  .cfg_hit  (cfg_hit)
);

// File: tb/test_sysctl_regs.sv
module test_sysctl_regs;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] sub_irq = 8'h00;
  logic [7:0] rdata;
  logic       host_irq;

  int    errors = 0;
  int    checks = 0;
  string phase = "R11";
  bit    done = 1'b0;

  // behavioural reference
  bit      map_cfg [256];
  int      mem [256];
  int      m_pend = 0, m_ena = 0, m_route = 0, m_line = 0;
  int      live = 0;

  always #(PERIOD/2) clk = ~clk;

  sysctl_regs i_sysctl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sub_irq(sub_irq), .host_irq(host_irq)
  );

  initial begin
    int bases [17] = '{'h60,'h64,'h68,'h6C,'h70,'h80,'h84,'h88,
                       'h98,'h9A,'h9C,'hA0,'hA1,'hE0,'hE4,'hFC,'hFF};
    int lens  [17] = '{2,3,3,3,3,3,3,3,2,2,4,1,1,1,2,1,1};
    for (int a = 0; a < 256; a++) begin map_cfg[a] = 1'b0; mem[a] = 0; end
    for (int g = 0; g < 17; g++)
      for (int k = 0; k < lens[g]; k++) map_cfg[bases[g] + k] = 1'b1;
  end

  function automatic int exp_read(int a);
    if (a == 'h08) return 3;
    if (a == 'h09) return 0;
    if (a == 'h50) return m_pend;
    if (a == 'h52) return m_ena;
    if (a == 'h54) return m_route;
    if (map_cfg[a]) return mem[a];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      live = 0;
      m_pend = 0; m_ena = 0; m_route = 0; m_line = 0;
      for (int a = 0; a < 256; a++) mem[a] = 0;
    end else begin
      if (live >= 2) begin
        int np;
        np = 0;
        for (int n = 0; n < 8; n++) begin
          int lv, pv;
          lv = (int'(sub_irq) >> n) & 1;
          pv = (m_pend >> n) & 1;
          if (lv != ((m_line >> n) & 1)) pv = lv;
          else if (wr_en && addr == 8'h50) pv = (int'(wdata) >> n) & 1;
          np = np | (pv << n);
        end
        m_pend = np;
        m_line = int'(sub_irq);
        if (wr_en) begin
          if (addr == 8'h52) m_ena = int'(wdata);
          if (addr == 8'h54) m_route = int'(wdata);
          if (map_cfg[addr]) mem[addr] = int'(wdata);
        end
      end
      if (live < 2) live++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // compare with the model a quarter period after every rising edge
  always begin
    @(posedge clk);
    #(PERIOD/4);
    if (!done) begin
      chk({phase, " rdata"}, int'(rdata), exp_read(int'(addr)));
      chk({phase, " host_irq"}, int'(host_irq), ((m_pend & m_ena) != 0) ? 1 : 0);
    end
  end

  task automatic wr(int a, int d);
    wr_en = 1'b1; addr = 8'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string tag, int a, int exp);
    wr_en = 1'b0; addr = 8'(a);
    @(posedge clk); #(PERIOD/4);
    chk(tag, int'(rdata), exp);
    @(negedge clk);
  endtask

  task automatic irq_is(string tag, int exp);
    @(posedge clk); #(PERIOD/4);
    chk(tag, int'(host_irq), exp);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    @(negedge clk);
    // R11: reset state
    phase = "R11";
    rd("R11 pending in reset", 'h50, 0);
    irq_is("R11 irq in reset", 0);
    rst_n = 1'b1;
    wr('h52, 'hFF);           // lands on an edge still held in reset
    rd("R11 enable after release", 'h52, 0);

    phase = "R1";
    rd("R1 rev lo", 'h08, 3);
    rd("R1 rev hi", 'h09, 0);
    wr('h08, 'h55); wr('h09, 'hAA);
    rd("R1 rev lo after write", 'h08, 3);
    rd("R1 rev hi after write", 'h09, 0);

    phase = "R2";
    wr('h54, 'hC3);
    rd("R2 routing", 'h54, 'hC3);
    wr('h50, 'h5A);
    rd("R2 pending", 'h50, 'h5A);
    wr('h52, 'h81);
    rd("R2 enable", 'h52, 'h81);

    phase = "R5";
    wr('h52, 'h00);
    irq_is("R5 masked", 0);
    wr('h52, 'h02);
    irq_is("R5 one enabled", 1);
    wr('h52, 'h01);
    irq_is("R5 disjoint", 0);

    phase = "R3";
    wr('h50, 'h00); wr('h52, 'hFF);
    sub_irq = 8'h10;
    rd("R3 line rise", 'h50, 'h10);
    irq_is("R3 irq from line", 1);
    wr('h50, 'h00);
    rd("R3 sw clear with line high", 'h50, 'h00);
    sub_irq = 8'h00;
    rd("R3 line fall", 'h50, 'h00);
    sub_irq = 8'h10;
    rd("R3 line rise again", 'h50, 'h10);

    phase = "R4";
    sub_irq = 8'h02;          // bit4 falls, bit1 rises, same edge as write of 00
    wr('h50, 'h00);
    rd("R4 collide zero write", 'h50, 'h02);
    sub_irq = 8'h00;          // bit1 falls while FF written
    wr('h50, 'hFF);
    rd("R4 collide ones write", 'h50, 'hFD);

    phase = "R6";
    wr('h98, 'h11); wr('h99, 'h22);
    rd("R6 low byte", 'h98, 'h11);
    rd("R6 high byte", 'h99, 'h22);
    wr('h99, 'h33);
    rd("R6 low untouched", 'h98, 'h11);
    wr('hE4, 'h7E);
    rd("R6 mode hi untouched", 'hE5, 0);

    phase = "R7";
    wr('h9C, 'h01); wr('h9D, 'h02); wr('h9E, 'h03); wr('h9F, 'h04);
    wr('h9E, 'hAA);
    rd("R7 byte0", 'h9C, 'h01);
    rd("R7 byte1", 'h9D, 'h02);
    rd("R7 byte2", 'h9E, 'hAA);
    rd("R7 byte3", 'h9F, 'h04);

    phase = "R8";
    wr('h64, 'hA1); wr('h66, 'hA3); wr('h67, 'hA4); wr('h8A, 'h8A);
    rd("R8 arr0", 'h64, 'hA1);
    rd("R8 arr2", 'h66, 'hA3);
    rd("R8 base+3 unmapped", 'h67, 0);
    rd("R8 last array", 'h8A, 'h8A);

    phase = "R9";
    wr('hA0, 'h0A); wr('hA1, 'h1A); wr('hFF, 'hF0);
    rd("R9 byte a0", 'hA0, 'h0A);
    rd("R9 byte a1", 'hA1, 'h1A);
    rd("R9 byte ff", 'hFF, 'hF0);

    phase = "R10";
    for (int a = 0; a < 256; a++)
      if (!map_cfg[a] && a != 'h50 && a != 'h52 && a != 'h54) wr(a, 'hA5);
    for (int a = 0; a < 256; a++) begin
      wr_en = 1'b0; addr = 8'(a);
      @(negedge clk);
    end
    rd("R10 unmapped 0x00", 'h00, 0);
    rd("R10 unmapped 0xFE", 'hFE, 0);

    phase = "R4";
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] == 4'h0) sub_irq = sub_irq ^ (8'h1 << lfsr[6:4]);
      wr_en = lfsr[7];
      addr  = lfsr[8] ? 8'h50 : (lfsr[9] ? 8'h52 : lfsr[23:16]);
      wdata = lfsr[31:24];
      @(negedge clk);
    end
    wr_en = 1'b0;

    phase = "R11";
    rst_n = 1'b0;
    @(negedge clk);
    rd("R11 pending after re-reset", 'h50, 0);
    rd("R11 pll after re-reset", 'h9F, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule